// File: doc/BRIEF.md
# Rewindable FIFO with Half-Full Status

A single-clock first-in first-out buffer holding 9-bit words, sized for a data byte plus one parity or framing bit. The number of words is a parameter, normally 256, 512 or 1024. A producer pulses a write strobe with a word, and a consumer pulses a read strobe. The word that was read appears on a registered output one cycle later, together with a one-cycle valid pulse. Three status outputs show whether the buffer is empty, full, or holding more than half its capacity.

The buffer can replay its contents. A rewind request moves the read position back to the first storage location and leaves the write position where it is. Every word written since reset then becomes readable again. This works only while fewer words than the depth have been written since reset. At the two edges a strobe passes straight through. A read issued together with a write on an empty buffer returns the incoming word at once. A write issued together with a read on a full buffer stores its word in the slot that the read frees.

Top module: `fifo_rewind`

## Requirements
- R1: After reset, empty is 1, full is 0, half_full is 0 and rd_valid is 0.
- R2: Words are read back in the order they were written. Each accepted read gives rd_valid=1 and the word on rd_data in the cycle after the read strobe.
- R3: A read strobe without a write strobe while empty is ignored. rd_valid stays 0, empty stays 1, and the next word written is the next word read.
- R4: full rises once the words written since reset exceed the words read by DEPTH. A write strobe without a read strobe while full is ignored, and the stored words are unchanged.
- R5: half_full rises on the write that takes the stored count to DEPTH/2+1. It falls only when a read brings the count back to exactly DEPTH/2.
- R6: A read and a write in the same cycle on a buffer that is neither empty nor full leave the count and the flags unchanged, and both words keep their order.
- R7: A rewind strobe with no read or write strobe moves the read position to location 0 and keeps the write position. Reads then replay from the first word written after reset, the flags follow the new count, and later writes append after the last word written.
- R8: A rewind strobe in a cycle that also carries a read or write strobe is ignored. That read or write proceeds normally.
- R9: A read and a write in the same cycle on an empty buffer deliver the written word on rd_data with rd_valid=1 in the next cycle, and empty stays 1.
- R10: A read and a write in the same cycle on a full buffer return the oldest word, store the new word as the youngest, and full stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per word |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read strobe, one cycle per word |
| rewind | input | 1 | Rewind request for the read position |
| rd_data | output | WIDTH | Registered word that was read |
| rd_valid | output | 1 | One-cycle pulse with each accepted read |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| half_full | output | 1 | More than DEPTH/2 words stored |

## Verification
The bench fills the buffer to exactly DEPTH and checks where half_full rises and where it falls. A design with an off-by-one threshold, or one that clears the flag on any read, would report half-full one word early or late. Both pass-through cases are tested. A design that gates the read with empty would drop the word that arrives on an empty buffer, and one that gates the write with full would lose the word offered to a full buffer, so the final drain would come out short. A rewind is issued together with a read to show that it is ignored, and then alone to show a full replay. A design that resets the write position, or that leaves the count stale after a rewind, would either overwrite replayed data or report empty too early.

// File: rtl/fifo_rewind.sv
module fifo_rewind #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             rewind,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             empty,
  output logic             full,
  output logic             half_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt, cnt_nx;
  logic             rd_ok, wr_ok, rew_ok;

  assign empty  = (cnt == '0);
  assign full   = (cnt == FULL_C);
  assign rd_ok  = rd_en && (!empty || wr_en);
  assign wr_ok  = wr_en && (!full || rd_en);
  assign rew_ok = rewind && !rd_en && !wr_en;
  assign cnt_nx = rew_ok ? {1'b0, wptr}
                         : cnt + {{AW{1'b0}}, wr_ok} - {{AW{1'b0}}, rd_ok};

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      cnt       <= '0;
      half_full <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid  <= rd_ok;
      cnt       <= cnt_nx;
      half_full <= (cnt_nx > HALF_C);
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) begin
        rd_data <= empty ? wr_data : mem[rptr];
        rptr    <= rptr + 1'b1;
      end
      if (rew_ok) rptr <= '0;
    end
  end
endmodule

module fifo_rewind_chk #(
  parameter int WIDTH = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic             rd_en,
  input logic             rewind,
  input logic [WIDTH-1:0] rd_data,
  input logic             rd_valid,
  input logic             empty,
  input logic             full,
  input logic             half_full
);
  // R4
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
  // R2
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !empty) |=> rd_valid);
  // R3
  empty_read_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en) |=> (!rd_valid && empty));
  // R4
  full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> full);
  // R5
  full_implies_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> half_full);
  // R9
  flow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && wr_en) |=> (rd_valid && empty && rd_data == $past(wr_data)));
  // R10
  flow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rd_en && wr_en) |=> (rd_valid && full));
  // R8
  rewind_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind && rd_en && !wr_en && !empty && !full) |=> (rd_valid && !full));
endmodule

bind fifo_rewind fifo_rewind_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/fifo_rewind_tb.sv
module fifo_rewind_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, rewind = 1'b0;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic       rd_valid, empty, full, half_full;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_rewind #(.WIDTH(9), .DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(logic w, logic [8:0] d, logic r, logic rw);
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r; rewind = rw;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; rewind = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 half_full", half_full, 0); chk("R1 rd_valid", rd_valid, 0);
  endtask

  task automatic t_order();
    cyc(1, 9'h101, 0, 0); cyc(1, 9'h0AA, 0, 0); cyc(1, 9'h055, 0, 0);
    chk("R2 not empty", empty, 0);
    cyc(0, 0, 1, 0); chk("R2 valid", rd_valid, 1); chk("R2 data0", rd_data, 9'h101);
    cyc(0, 0, 1, 0); chk("R2 data1", rd_data, 9'h0AA);
    cyc(0, 0, 1, 0); chk("R2 data2", rd_data, 9'h055);
    chk("R2 empty after drain", empty, 1);
    cyc(0, 0, 0, 0); chk("R2 valid is a pulse", rd_valid, 0);
  endtask

  task automatic t_empty_read();
    cyc(0, 0, 1, 0);
    chk("R3 no valid", rd_valid, 0); chk("R3 still empty", empty, 1);
    cyc(1, 9'h1C3, 0, 0); cyc(0, 0, 1, 0);
    chk("R3 next word", rd_data, 9'h1C3); chk("R3 empty", empty, 1);
  endtask

  task automatic t_flow_empty();
    cyc(1, 9'h17E, 1, 0);
    chk("R9 valid", rd_valid, 1); chk("R9 data", rd_data, 9'h17E);
    chk("R9 empty kept", empty, 1);
    cyc(0, 0, 1, 0); chk("R9 nothing left", rd_valid, 0);
  endtask

  task automatic t_simul();
    cyc(1, 9'h011, 0, 0); cyc(1, 9'h022, 0, 0);
    cyc(1, 9'h033, 1, 0);
    chk("R6 data", rd_data, 9'h011); chk("R6 not empty", empty, 0);
    cyc(0, 0, 1, 0); chk("R6 second", rd_data, 9'h022);
    cyc(0, 0, 1, 0); chk("R6 third", rd_data, 9'h033);
    chk("R6 empty", empty, 1);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < DEPTH/2; i++) cyc(1, 9'(i), 0, 0);
    chk("R5 at half not set", half_full, 0);
    cyc(1, 9'(DEPTH/2), 0, 0);
    chk("R5 above half set", half_full, 1);
    for (int i = DEPTH/2 + 1; i < DEPTH; i++) cyc(1, 9'(i), 0, 0);
    chk("R4 full", full, 1);
    cyc(1, 9'h1FF, 0, 0);
    chk("R4 still full", full, 1);
    cyc(1, 9'h0EE, 1, 0);
    chk("R10 oldest", rd_data, 0); chk("R10 full kept", full, 1);
    for (int k = 1; k <= DEPTH; k++) begin
      cyc(0, 0, 1, 0);
      chk("R4 R10 drain data", rd_data, (k < DEPTH) ? k : 9'h0EE);
      if (k == DEPTH/2 - 1) chk("R5 still set", half_full, 1);
      if (k == DEPTH/2) chk("R5 cleared at half", half_full, 0);
      if (k == 1) chk("R4 full falls", full, 0);
    end
    chk("R4 empty at end", empty, 1);
  endtask

  task automatic t_rewind();
    do_reset();
    for (int i = 0; i < 5; i++) cyc(1, 9'(9'h100 + i), 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0);
    chk("R2 third", rd_data, 9'h102);
    cyc(0, 0, 1, 1);
    chk("R8 rewind ignored", rd_data, 9'h103);
    cyc(0, 0, 0, 1);
    chk("R7 not empty", empty, 0); chk("R7 half_full", half_full, 0);
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 1, 0);
      chk("R7 replay", rd_data, 9'h100 + i);
    end
    chk("R7 empty after replay", empty, 1);
    cyc(1, 9'h1AB, 0, 0); cyc(0, 0, 1, 0);
    chk("R7 write pointer kept", rd_data, 9'h1AB);
  endtask

  initial begin
    t_reset();
    t_order();
    t_empty_read();
    t_flow_empty();
    t_simul();
    t_full();
    t_rewind();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule